// File: doc/BRIEF.md
# Transmit/Receive FIFO Pair with Level Flags and Receive Idle Timeout

This block holds the data words that travel between a processor-facing register interface and a serial shift engine. It contains two independent first-in first-out buffers, one for outgoing words and one for incoming words, each with its own push and pop strobes, show-ahead read data, full and empty flags and an occupancy count. A programmable three-bit threshold per buffer raises a level flag. The two flags use opposite senses: the outgoing buffer flags "running low" and the incoming buffer flags "filling up".

The receive side carries two extra status flags. A sticky overrun flag records that a word arrived while the receive buffer had no room and was thrown away. An idle-timeout flag records that words have sat in the receive buffer unread for too long. The timeout window is shorter when the block serves as bus controller and longer when it serves as bus target. Reading a word clears the timeout automatically. Both sticky flags also have their own write-one-to-clear strobe.

A one-cycle clear strobe per buffer returns that buffer to the empty state. It does not touch anything outside the buffer.

The timeout is an explicit three-state machine:
- IDLE: the receive buffer is empty.
- COUNT: the window is running.
- FIRED: the flag is raised.

Its transitions are:
- IDLE to COUNT on a push into the empty buffer.
- COUNT to IDLE when the buffer drains or is cleared.
- COUNT to FIRED when the window elapses.
- FIRED to COUNT on a pop or on a write-one-to-clear.
- FIRED to IDLE on a clear.

Each buffer's occupancy is also tracked by a three-state machine (EMPTY, PARTIAL, FULL):
- EMPTY to PARTIAL on an accepted push.
- PARTIAL to FULL when a push fills the last slot.
- PARTIAL to EMPTY when a pop takes the last word.
- FULL to PARTIAL on a pop without a push.
- Any state to EMPTY on a clear.

Top module: `serial_fifo_status`

## Requirements
- R1: After reset both buffers are empty, not full, with level 0. The overrun and timeout flags are low. The transmit level flag is high and the receive level flag is low.
- R2: Words leave each buffer in the order they were pushed. The read-data output always presents the oldest stored word, and the level equals the number of stored words.
- R3: A buffer is full exactly when it holds DEPTH words. A push into a full transmit buffer is ignored, and a pop from an empty buffer is ignored. A simultaneous push and pop on an empty buffer stores the pushed word.
- R4: The receive level flag is high exactly when the receive level is strictly greater than the receive threshold input.
- R5: The transmit level flag is high exactly when the transmit level is less than or equal to the transmit threshold input.
- R6: A push into a full receive buffer without a pop in the same cycle discards the word, leaves contents and level unchanged, and sets the overrun flag. The flag stays set until its write-one-to-clear strobe is high at a clock edge. A new overrun in the same cycle as that strobe wins, and the flag stays set.
- R7: A push and a pop in the same cycle on a full receive buffer are both accepted. The level stays at DEPTH and the overrun flag is not set.
- R8: In controller mode (slave_mode=0), the timeout flag rises at the (TO_MASTER_LIM+1)-th clock edge after the last restart of the window, if the receive buffer stayed non-empty and unread. A push into a non-empty buffer does not restart the window.
- R9: In target mode (slave_mode=1), the same rule applies with TO_SLAVE_LIM in place of TO_MASTER_LIM.
- R10: An accepted receive pop, or the timeout write-one-to-clear strobe, lowers the timeout flag at that clock edge.
- R11: The timeout window restarts on every accepted receive pop and on every push into an empty receive buffer.
- R12: A clear strobe empties its buffer at that edge: empty goes to 1, full to 0 and level to 0. A push in the same cycle is dropped without setting overrun. The next pushed word is the next word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode | input | 1 | 1 selects the longer target-mode timeout window |
| tx_push | input | 1 | Write a word into the transmit buffer |
| tx_wdata | input | DATA_W | Transmit write data |
| tx_pop | input | 1 | Remove the oldest transmit word |
| tx_clear | input | 1 | One-cycle transmit buffer clear |
| tx_thresh | input | TH_W | Transmit low-level threshold |
| tx_rdata | output | DATA_W | Oldest transmit word |
| tx_full | output | 1 | Transmit buffer full |
| tx_empty | output | 1 | Transmit buffer empty |
| tx_level | output | clog2(DEPTH+1) | Transmit word count |
| tx_low | output | 1 | Transmit level <= threshold |
| rx_push | input | 1 | Write a received word |
| rx_wdata | input | DATA_W | Receive write data |
| rx_pop | input | 1 | Remove the oldest received word |
| rx_clear | input | 1 | One-cycle receive buffer clear |
| rx_thresh | input | TH_W | Receive high-level threshold |
| rx_rdata | output | DATA_W | Oldest received word |
| rx_full | output | 1 | Receive buffer full |
| rx_empty | output | 1 | Receive buffer empty |
| rx_level | output | clog2(DEPTH+1) | Receive word count |
| rx_high | output | 1 | Receive level > threshold |
| rx_ovr | output | 1 | Sticky receive overrun flag |
| rx_ovr_w1c | input | 1 | Clear strobe for rx_ovr |
| rx_tmo | output | 1 | Receive idle-timeout flag |
| rx_tmo_w1c | input | 1 | Clear strobe for rx_tmo |

## Verification
The bench builds the block with DEPTH=4, DATA_W=32 and TH_W=3. With these values every level 0 to 4 and threshold settings both below and above the maximum level (0 to 7) can be reached. The timeout windows are shortened to TO_MASTER_LIM=12 and TO_SLAVE_LIM=40. The exact edge at which the timeout rises can then be checked in both modes, together with restart-by-pop and the no-restart case for a push into a non-empty buffer, within a few hundred cycles. The same timeout machine and counter also serve the default windows of 64 and 576.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    // Occupancy state of one buffer
    typedef enum logic [1:0] {
        FL_EMPTY   = 2'd0,
        FL_PARTIAL = 2'd1,
        FL_FULL    = 2'd2
    } fill_state_e;

    // Receive idle-timeout machine
    typedef enum logic [1:0] {
        TO_IDLE  = 2'd0,
        TO_COUNT = 2'd1,
        TO_FIRED = 2'd2
    } tmo_state_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sfs_fifo_ring.sv
module sfs_fifo_ring
    import sfs_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 4,
    localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic              full,
    output logic              empty,
    output logic [CW-1:0]     level
);

    fill_state_e       st, st_n;
    logic [CW-1:0]     lvl_q;
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [DATA_W-1:0] mem [DEPTH];
    logic              pop_ok, push_ok;

    assign pop_ok  = pop && (st != FL_EMPTY) && !clear;
    assign push_ok = push && !clear && ((st != FL_FULL) || pop_ok);

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // storage, no reset needed
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    // state register, pointers and level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= FL_EMPTY;
            lvl_q  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (clear) begin
            st     <= FL_EMPTY;
            lvl_q  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            st <= st_n;
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            if (push_ok && !pop_ok)      lvl_q <= lvl_q + CW'(1);
            else if (pop_ok && !push_ok) lvl_q <= lvl_q - CW'(1);
        end
    end

    // next state
    always_comb begin
        st_n = st;
        unique case (st)
            FL_EMPTY: begin
                if (push_ok) st_n = FL_PARTIAL;
            end
            FL_PARTIAL: begin
                if (push_ok && !pop_ok && lvl_q == CW'(DEPTH - 1))
                    st_n = FL_FULL;
                else if (pop_ok && !push_ok && lvl_q == CW'(1))
                    st_n = FL_EMPTY;
            end
            FL_FULL: begin
                if (pop_ok && !push_ok) st_n = FL_PARTIAL;
            end
            default: st_n = FL_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        empty = 1'b0;
        full  = 1'b0;
        unique case (st)
            FL_EMPTY:   empty = 1'b1;
            FL_PARTIAL: ;
            FL_FULL:    full = 1'b1;
            default:    empty = 1'b1;
        endcase
        level = lvl_q;
        rdata = mem[rd_ptr];
    end

    AST_FULL_AT_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (level == CW'(DEPTH))) else $error("full without DEPTH words"); // R3
    AST_FULL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clear) |=> (full && $stable(level))) else $error("full buffer grew"); // R3
    AST_EMPTY_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !clear) |=> (empty && level == '0)) else $error("pop from empty"); // R3
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (empty && !full && level == '0)) else $error("clear left data"); // R12

endmodule

// File: rtl/sfs_level_cmp.sv
module sfs_level_cmp #(
    parameter int unsigned CW    = 3,
    parameter int unsigned TW    = 3,
    parameter bit          ABOVE = 1'b1,
    localparam int unsigned MW   = (CW > TW) ? CW : TW
) (
    input  logic [CW-1:0] level,
    input  logic [TW-1:0] thresh,
    output logic          flag
);

    logic [MW-1:0] lvl_w, th_w;
    assign lvl_w = MW'(level);
    assign th_w  = MW'(thresh);

    generate
        if (ABOVE) begin : g_above
            assign flag = (lvl_w > th_w);
        end else begin : g_at_or_below
            assign flag = (lvl_w <= th_w);
        end
    endgenerate

endmodule

// File: rtl/sfs_rx_idle_timer.sv
module sfs_rx_idle_timer
    import sfs_pkg::*;
#(
    parameter int unsigned MASTER_LIM = 64,
    parameter int unsigned SLAVE_LIM  = 576,
    localparam int unsigned LIM_MAX   = (MASTER_LIM > SLAVE_LIM) ? MASTER_LIM : SLAVE_LIM,
    localparam int unsigned TCW       = $clog2(LIM_MAX + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slave_mode,
    input  logic clear,
    input  logic empty,
    input  logic push_ok,
    input  logic pop_ok,
    input  logic w1c,
    output logic flag
);

    tmo_state_e     st, st_n;
    logic [TCW-1:0] cnt, cnt_n;
    logic [TCW-1:0] lim;

    assign lim = slave_mode ? TCW'(SLAVE_LIM) : TCW'(MASTER_LIM);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= TO_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    // next state
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        unique case (st)
            TO_IDLE: begin
                if (!clear && push_ok) begin
                    st_n  = TO_COUNT;
                    cnt_n = '0;
                end
            end
            TO_COUNT: begin
                if (clear) begin
                    st_n  = TO_IDLE;
                    cnt_n = '0;
                end else if (empty) begin
                    cnt_n = '0;
                    if (!push_ok) st_n = TO_IDLE;
                end else if (pop_ok || w1c) begin
                    cnt_n = '0;
                end else if (cnt >= lim) begin
                    st_n = TO_FIRED;
                end else begin
                    cnt_n = cnt + TCW'(1);
                end
            end
            TO_FIRED: begin
                if (clear) begin
                    st_n  = TO_IDLE;
                    cnt_n = '0;
                end else if (pop_ok || w1c) begin
                    st_n  = TO_COUNT;
                    cnt_n = '0;
                end
            end
            default: begin
                st_n  = TO_IDLE;
                cnt_n = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        unique case (st)
            TO_FIRED: flag = 1'b1;
            default:  flag = 1'b0;
        endcase
    end

    AST_TMO_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        flag |-> !empty) else $error("timeout with empty buffer"); // R8
    AST_POP_DROPS_TMO: assert property (@(posedge clk) disable iff (!rst_n)
        pop_ok |=> !flag) else $error("pop did not clear timeout"); // R10
    AST_W1C_DROPS_TMO: assert property (@(posedge clk) disable iff (!rst_n)
        w1c |=> !flag) else $error("w1c did not clear timeout"); // R10
    AST_TMO_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !pop_ok && !w1c && !clear) |=> flag) else $error("timeout dropped by itself"); // R8

endmodule

// File: rtl/serial_fifo_status.sv
module serial_fifo_status #(
    parameter int unsigned DATA_W        = 32,
    parameter int unsigned DEPTH         = 4,
    parameter int unsigned TH_W          = 3,
    parameter int unsigned TO_MASTER_LIM = 64,
    parameter int unsigned TO_SLAVE_LIM  = 576,
    localparam int unsigned CW           = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              tx_pop,
    input  logic              tx_clear,
    input  logic [TH_W-1:0]   tx_thresh,
    output logic [DATA_W-1:0] tx_rdata,
    output logic              tx_full,
    output logic              tx_empty,
    output logic [CW-1:0]     tx_level,
    output logic              tx_low,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_wdata,
    input  logic              rx_pop,
    input  logic              rx_clear,
    input  logic [TH_W-1:0]   rx_thresh,
    output logic [DATA_W-1:0] rx_rdata,
    output logic              rx_full,
    output logic              rx_empty,
    output logic [CW-1:0]     rx_level,
    output logic              rx_high,
    output logic              rx_ovr,
    input  logic              rx_ovr_w1c,
    output logic              rx_tmo,
    input  logic              rx_tmo_w1c
);

    logic rx_pop_ok, rx_push_ok, rx_drop;

    sfs_fifo_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .clear(tx_clear),
        .push(tx_push), .wdata(tx_wdata), .pop(tx_pop), .rdata(tx_rdata),
        .full(tx_full), .empty(tx_empty), .level(tx_level)
    );

    sfs_fifo_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .clear(rx_clear),
        .push(rx_push), .wdata(rx_wdata), .pop(rx_pop), .rdata(rx_rdata),
        .full(rx_full), .empty(rx_empty), .level(rx_level)
    );

    sfs_level_cmp #(.CW(CW), .TW(TH_W), .ABOVE(1'b0)) u_tx_cmp (
        .level(tx_level), .thresh(tx_thresh), .flag(tx_low)
    );

    sfs_level_cmp #(.CW(CW), .TW(TH_W), .ABOVE(1'b1)) u_rx_cmp (
        .level(rx_level), .thresh(rx_thresh), .flag(rx_high)
    );

    // receive-side acceptance as seen at the ports
    assign rx_pop_ok  = rx_pop && !rx_empty && !rx_clear;
    assign rx_push_ok = rx_push && !rx_clear && (!rx_full || rx_pop_ok);
    assign rx_drop    = rx_push && !rx_clear && rx_full && !rx_pop;

    sfs_rx_idle_timer #(.MASTER_LIM(TO_MASTER_LIM), .SLAVE_LIM(TO_SLAVE_LIM)) u_rx_timer (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .clear(rx_clear),
        .empty(rx_empty), .push_ok(rx_push_ok), .pop_ok(rx_pop_ok),
        .w1c(rx_tmo_w1c), .flag(rx_tmo)
    );

    // sticky overrun: a new drop outranks the clear strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          rx_ovr <= 1'b0;
        else if (rx_drop)    rx_ovr <= 1'b1;
        else if (rx_ovr_w1c) rx_ovr <= 1'b0;
    end

    AST_OVR_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full && !rx_pop && !rx_clear) |=> (rx_ovr && rx_full)) else $error("drop without overrun"); // R6
    AST_OVR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ovr && !rx_ovr_w1c) |=> rx_ovr) else $error("overrun flag lost"); // R6
    AST_FULL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && rx_push && rx_pop && !rx_clear && !rx_ovr) |=> (!rx_ovr && rx_full)) else $error("full push+pop mishandled"); // R7

endmodule

// File: tb/test_serial_fifo_status.sv
module test_serial_fifo_status;

    localparam int unsigned DW  = 32;
    localparam int unsigned DEP = 4;
    localparam int unsigned TW  = 3;
    localparam int unsigned ML  = 12;
    localparam int unsigned SL  = 40;
    localparam int unsigned CW  = $clog2(DEP + 1);

    // {txpush,txpop,rxpush,rxpop}, thresh, byte, exp tx lvl, exp rx lvl, exp tx_low, exp rx_high, pad
    localparam int NV = 13;
    localparam logic [23:0] VEC [NV] = '{
        {4'b1010, 3'd2, 8'h11, 3'd1, 3'd1, 1'b1, 1'b0, 1'b0},
        {4'b1010, 3'd2, 8'h22, 3'd2, 3'd2, 1'b1, 1'b0, 1'b0},
        {4'b1010, 3'd2, 8'h33, 3'd3, 3'd3, 1'b0, 1'b1, 1'b0},
        {4'b1010, 3'd2, 8'h44, 3'd4, 3'd4, 1'b0, 1'b1, 1'b0},
        {4'b1000, 3'd7, 8'h55, 3'd4, 3'd4, 1'b1, 1'b0, 1'b0},
        {4'b0101, 3'd3, 8'h00, 3'd3, 3'd3, 1'b1, 1'b0, 1'b0},
        {4'b1111, 3'd3, 8'h66, 3'd3, 3'd3, 1'b1, 1'b0, 1'b0},
        {4'b0101, 3'd0, 8'h00, 3'd2, 3'd2, 1'b0, 1'b1, 1'b0},
        {4'b0101, 3'd1, 8'h00, 3'd1, 3'd1, 1'b1, 1'b0, 1'b0},
        {4'b0101, 3'd0, 8'h00, 3'd0, 3'd0, 1'b1, 1'b0, 1'b0},
        {4'b0101, 3'd0, 8'h00, 3'd0, 3'd0, 1'b1, 1'b0, 1'b0},
        {4'b1111, 3'd0, 8'h77, 3'd1, 3'd1, 1'b0, 1'b1, 1'b0},
        {4'b0101, 3'd4, 8'h00, 3'd0, 3'd0, 1'b1, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slave_mode = 1'b0;
    logic tx_push = 1'b0, tx_pop = 1'b0, tx_clear = 1'b0;
    logic rx_push = 1'b0, rx_pop = 1'b0, rx_clear = 1'b0;
    logic rx_ovr_w1c = 1'b0, rx_tmo_w1c = 1'b0;
    logic [DW-1:0] tx_wdata = '0, rx_wdata = '0;
    logic [TW-1:0] tx_thresh = '0, rx_thresh = '0;
    logic [DW-1:0] tx_rdata, rx_rdata;
    logic tx_full, tx_empty, tx_low, rx_full, rx_empty, rx_high, rx_ovr, rx_tmo;
    logic [CW-1:0] tx_level, rx_level;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    serial_fifo_status #(
        .DATA_W(DW), .DEPTH(DEP), .TH_W(TW),
        .TO_MASTER_LIM(ML), .TO_SLAVE_LIM(SL)
    ) i_serial_fifo_status (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_clear(tx_clear),
        .tx_thresh(tx_thresh), .tx_rdata(tx_rdata), .tx_full(tx_full), .tx_empty(tx_empty),
        .tx_level(tx_level), .tx_low(tx_low),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_clear(rx_clear),
        .rx_thresh(rx_thresh), .rx_rdata(rx_rdata), .rx_full(rx_full), .rx_empty(rx_empty),
        .rx_level(rx_level), .rx_high(rx_high), .rx_ovr(rx_ovr), .rx_ovr_w1c(rx_ovr_w1c),
        .rx_tmo(rx_tmo), .rx_tmo_w1c(rx_tmo_w1c)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // advance one edge; inputs settle 1 ns after it
    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [DW-1:0] txq[$];
        logic [DW-1:0] rxq[$];

        // ---- R1: reset state
        #9 rst_n = 1'b1;
        cyc();
        check("R1 tx_empty", 32'(tx_empty), 32'd1);
        check("R1 rx_empty", 32'(rx_empty), 32'd1);
        check("R1 levels", 32'({tx_level, rx_level}), 32'd0);
        check("R1 full", 32'({tx_full, rx_full}), 32'd0);
        check("R1 tx_low", 32'(tx_low), 32'd1);
        check("R1 rx_high", 32'(rx_high), 32'd0);
        check("R1 ovr/tmo", 32'({rx_ovr, rx_tmo}), 32'd0);

        // ---- table walk: R2, R3, R4, R5
        for (int i = 0; i < NV; i++) begin
            logic [23:0] v;
            logic tpo, rpo, tpu, rpu;
            v = VEC[i];
            tx_push   = v[23]; tx_pop = v[22]; rx_push = v[21]; rx_pop = v[20];
            tx_thresh = v[19:17]; rx_thresh = v[19:17];
            tx_wdata  = {4{v[16:9]}}; rx_wdata = {4{v[16:9]}};
            tpo = v[22] && (txq.size() > 0);
            tpu = v[23] && ((txq.size() < DEP) || tpo);
            rpo = v[20] && (rxq.size() > 0);
            rpu = v[21] && ((rxq.size() < DEP) || rpo);
            cyc();
            if (tpo) void'(txq.pop_front());
            if (tpu) txq.push_back({4{v[16:9]}});
            if (rpo) void'(rxq.pop_front());
            if (rpu) rxq.push_back({4{v[16:9]}});
            check($sformatf("R2/R3 tx_level step %0d", i), 32'(tx_level), 32'(v[8:6]));
            check($sformatf("R2/R3 rx_level step %0d", i), 32'(rx_level), 32'(v[5:3]));
            check($sformatf("R5 tx_low step %0d", i), 32'(tx_low), 32'(v[2]));
            check($sformatf("R4 rx_high step %0d", i), 32'(rx_high), 32'(v[1]));
            check($sformatf("R3 tx_full step %0d", i), 32'(tx_full), 32'(v[8:6] == 3'd4));
            if (txq.size() > 0) check($sformatf("R2 tx head step %0d", i), tx_rdata, txq[0]);
            if (rxq.size() > 0) check($sformatf("R2 rx head step %0d", i), rx_rdata, rxq[0]);
        end
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
        tx_thresh = 0; rx_thresh = 0;
        // both buffers now hold 0x77777777 is popped: level 0
        cyc();

        // ---- R6: overrun
        for (int k = 0; k < 4; k++) begin
            rx_push = 1'b1; rx_wdata = 32'hA000_0000 + 32'(k);
            cyc();
        end
        rx_wdata = 32'hA000_0004;
        cyc();
        rx_push = 1'b0;
        check("R6 level after drop", 32'(rx_level), 32'd4);
        check("R6 ovr set", 32'(rx_ovr), 32'd1);
        check("R6 head intact", rx_rdata, 32'hA000_0000);
        cyc();
        check("R6 ovr sticky", 32'(rx_ovr), 32'd1);
        rx_ovr_w1c = 1'b1;
        cyc();
        rx_ovr_w1c = 1'b0;
        check("R6 ovr cleared", 32'(rx_ovr), 32'd0);
        rx_push = 1'b1; rx_ovr_w1c = 1'b1; rx_wdata = 32'hA000_0005;
        cyc();
        rx_push = 1'b0; rx_ovr_w1c = 1'b0;
        check("R6 set beats w1c", 32'(rx_ovr), 32'd1);
        rx_ovr_w1c = 1'b1;
        cyc();
        rx_ovr_w1c = 1'b0;
        check("R6 ovr cleared again", 32'(rx_ovr), 32'd0);

        // ---- R7: push+pop on full
        rx_push = 1'b1; rx_pop = 1'b1; rx_wdata = 32'hA000_0006;
        cyc();
        rx_push = 1'b0; rx_pop = 1'b0;
        check("R7 level stays full", 32'(rx_level), 32'd4);
        check("R7 no overrun", 32'(rx_ovr), 32'd0);
        check("R7 head advanced", rx_rdata, 32'hA000_0001);

        // ---- R12: clear
        rx_clear = 1'b1; rx_push = 1'b1; rx_wdata = 32'hDEAD_BEEF;
        cyc();
        rx_clear = 1'b0; rx_push = 1'b0;
        check("R12 rx empty", 32'(rx_empty), 32'd1);
        check("R12 rx not full", 32'(rx_full), 32'd0);
        check("R12 rx level", 32'(rx_level), 32'd0);
        check("R12 no overrun", 32'(rx_ovr), 32'd0);
        tx_push = 1'b1; tx_wdata = 32'h1;
        cyc();
        tx_wdata = 32'h2;
        cyc();
        tx_push = 1'b0; tx_clear = 1'b1;
        cyc();
        tx_clear = 1'b0;
        check("R12 tx empty", 32'({tx_empty, tx_level}), 32'({1'b1, 3'd0}));
        tx_push = 1'b1; tx_wdata = 32'hC0DE_0001;
        cyc();
        tx_push = 1'b0;
        check("R12 tx next word", tx_rdata, 32'hC0DE_0001);

        // ---- R8 / R11: controller-mode window, push into non-empty does not restart
        rx_clear = 1'b1;
        cyc();
        rx_clear = 1'b0;
        rx_push = 1'b1; rx_wdata = 32'hB0;
        cyc();                              // E0
        rx_push = 1'b0;
        cyc(); cyc();                       // E1, E2
        rx_push = 1'b1; rx_wdata = 32'hB1;
        cyc();                              // E3
        rx_push = 1'b0;
        repeat (ML - 3) cyc();              // E_ML
        check("R8 no timeout at limit", 32'(rx_tmo), 32'd0);
        cyc();
        check("R8 timeout after limit+1", 32'(rx_tmo), 32'd1);

        // ---- R10: pop clears, R11: pop restarts
        rx_pop = 1'b1;
        cyc();                              // P0
        rx_pop = 1'b0;
        check("R10 pop clears timeout", 32'(rx_tmo), 32'd0);
        repeat (ML) cyc();
        check("R11 restarted window not yet elapsed", 32'(rx_tmo), 32'd0);
        cyc();
        check("R11 timeout after restart", 32'(rx_tmo), 32'd1);
        rx_tmo_w1c = 1'b1;
        cyc();
        rx_tmo_w1c = 1'b0;
        check("R10 w1c clears timeout", 32'(rx_tmo), 32'd0);

        // ---- R9: target-mode window
        rx_clear = 1'b1;
        cyc();
        rx_clear = 1'b0;
        slave_mode = 1'b1;
        rx_push = 1'b1; rx_wdata = 32'hC0;
        cyc();                              // E0
        rx_push = 1'b0;
        repeat (ML + 1) cyc();
        check("R9 controller limit ignored", 32'(rx_tmo), 32'd0);
        repeat (SL - ML - 1) cyc();         // E_SL
        check("R9 no timeout at limit", 32'(rx_tmo), 32'd0);
        cyc();
        check("R9 timeout after limit+1", 32'(rx_tmo), 32'd1);

        finish_run();
    end

endmodule